// File: doc/BRIEF.md
# Third-Order Delta-Sigma Division Ratio Modulator

This block produces the division ratio that a fractional-N feedback divider needs on every divided-clock cycle. The divider steps in half units, so the ratio is expressed in half-steps. An 8-bit integer word sets the coarse ratio. The top bit of a 24-bit fraction word is added directly as one half-step. The lower 23 fraction bits pass through a noise-shaping modulator built from three cascaded accumulators. That modulator adds a small signed offset to the ratio, so that over time the average ratio lands on the exact programmed fraction.

An optional dither bit from a 23-bit linear feedback shift register can be added to the least significant bit of the modulator input. This breaks up idle tones when the fraction is a simple value. The block runs on the divided clock and updates its ratio once on each rising edge. Its reset is asynchronous and active low.

Top module: `frac_ratio_mod`

## Requirements
- R1: While rst_n is low, ratio is 0, all three accumulators and the carry history are zero, and the shift register holds the seed (default 23'h1ACE5; a zero seed is replaced by 1), so the register is never all zeros.
- R2: On each rising clk edge out of reset, ratio becomes (2·int_word + frac_word[23] + y) modulo 2^(INT_W+2), using the inputs present at that edge. With frac_word[22:0] = 0 and dither_en = 0, starting from reset, y stays 0.
- R3: The modulator offset y always lies between −3 and +4 inclusive.
- R4: With frac_word[22:0] = 23'h200000 (one quarter) and dither off, the offsets over any 1024 consecutive edges sum to 256, give or take at most 3.
- R5: The first accumulator's input is frac_word[22:0] plus the dither bit (shift register bit 22, the value before the shift) when dither_en is 1. When dither_en is 0, the input is frac_word[22:0] alone.
- R6: The 23-bit shift register advances on every edge out of reset, whatever the value of dither_en. The new bit 0 is bit 22 XOR bit 17, and the other bits shift up by one place.
- R7: frac_word[23] adds exactly one half-step to ratio and does not enter the modulator.
- R8: The ratio wraps modulo 2^(INT_W+2). A negative offset with int_word = 0 gives a value near 2^(INT_W+2), for example 1023 for −1 at the defaults.
- R9: Each of the three 23-bit accumulators adds its input to its stored value and keeps the low 23 bits; its carry is bit 23 of that sum. Stage 2 takes stage 1's new value and stage 3 takes stage 2's new value. The offset is y = c1 + c2 − c2' + c3 − 2·c3' + c3'', where ' marks the value at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock; the ratio updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_word | input | INT_W | Integer part of the ratio, in whole steps |
| frac_word | input | FRAC_W | Fraction; the top bit is a half-step and the lower bits are noise shaped |
| dither_en | input | 1 | Adds the pseudo-random bit to the modulator input when high |
| ratio | output | INT_W+2 | Division ratio in half-steps |

## Verification
The bench builds the block with its default parameters: an 8-bit integer word, a 24-bit fraction, feedback tap 17 and seed 23'h1ACE5. With these values the full 23-bit accumulator width can be driven to all ones, where it carries on almost every edge. An integer word of zero makes the 10-bit output wrap whenever the offset goes negative. A quarter fraction gives an exact carry count over 1024 edges. A behavioural model built on integers and queues predicts the output on every edge, through dither on and off and through a reset in the middle of a run.

// File: rtl/frm_pkg.sv
package frm_pkg;

    // Number of cascaded accumulator stages in the noise shaper.
    localparam int MASH_ORDER = 3;

    // Signed offset from the carry combiner: the range is -3..+4.
    typedef logic signed [3:0] mash_ofs_t;

    // Extend a one-bit carry to the signed offset type.
    function automatic mash_ofs_t carry_ext(input logic c);
        return mash_ofs_t'({3'b000, c});
    endfunction

endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
    parameter int             W    = 23,
    parameter int             TAP  = 17,
    parameter logic [W-1:0]   SEED = 'h1ACE5
) (
    input  logic clk,
    input  logic rst_n,
    output logic dbit
);

    // A zero seed would lock the register; fall back to one.
    localparam logic [W-1:0] SEED_SAFE = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sr = {s_q.sr[W-2:0], s_q.sr[W-1] ^ s_q.sr[TAP]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sr <= SEED_SAFE;
        end else begin
            s_q <= s_d;
        end
    end

    // The dither bit is the value before this edge's shift.
    assign dbit = s_q.sr[W-1];

endmodule

// File: rtl/mash_stage.sv
module mash_stage #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W:0]   in_val,
    output logic [W-1:0] acc_next,
    output logic         carry
);

    typedef struct packed {
        logic [W-1:0] acc;
    } stage_st_t;

    stage_st_t  s_d, s_q;
    logic [W:0] sum_w;

    always_comb begin
        s_d     = s_q;
        sum_w   = {1'b0, s_q.acc} + in_val;
        s_d.acc = sum_w[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.acc <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_next = s_d.acc;
    assign carry    = sum_w[W];

endmodule

// File: rtl/noise_combine.sv
module noise_combine
    import frm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MASH_ORDER-1:0] cy,
    output mash_ofs_t             ofs
);

    typedef struct packed {
        logic c2_p;
        logic c3_p;
        logic c3_pp;
    } hist_st_t;

    hist_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.c2_p  = cy[1];
        s_d.c3_p  = cy[2];
        s_d.c3_pp = s_q.c3_p;
        // First difference on stage two, second difference on stage three.
        ofs = carry_ext(cy[0])
            + carry_ext(cy[1]) - carry_ext(s_q.c2_p)
            + carry_ext(cy[2]) - (carry_ext(s_q.c3_p) <<< 1) + carry_ext(s_q.c3_pp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/frac_ratio_mod.sv
module frac_ratio_mod
    import frm_pkg::*;
#(
    parameter int                   INT_W     = 8,
    parameter int                   FRAC_W    = 24,
    parameter int                   LFSR_TAP  = 17,
    parameter logic [FRAC_W-2:0]    LFSR_SEED = 'h1ACE5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_word,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic              dither_en,
    output logic [INT_W+1:0]  ratio
);

    localparam int ACC_W = FRAC_W - 1;
    localparam int OUT_W = INT_W + 2;

    typedef struct packed {
        logic [OUT_W-1:0] ratio;
    } top_st_t;

    top_st_t               s_d, s_q;
    logic                  dbit;
    logic [ACC_W:0]        stg_in  [MASH_ORDER];
    logic [ACC_W-1:0]      stg_acc [MASH_ORDER];
    logic [MASH_ORDER-1:0] stg_cy;
    mash_ofs_t             ofs;
    logic [OUT_W-1:0]      base_w;
    logic [OUT_W-1:0]      ofs_w;

    dither_lfsr #(
        .W    (ACC_W),
        .TAP  (LFSR_TAP),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .dbit  (dbit)
    );

    for (genvar k = 0; k < MASH_ORDER; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stg_in[k] = {1'b0, frac_word[ACC_W-1:0]}
                             + {{ACC_W{1'b0}}, dither_en & dbit};
        end else begin : g_tail
            assign stg_in[k] = {1'b0, stg_acc[k-1]};
        end
        mash_stage #(
            .W (ACC_W)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_val   (stg_in[k]),
            .acc_next (stg_acc[k]),
            .carry    (stg_cy[k])
        );
    end

    noise_combine u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .cy    (stg_cy),
        .ofs   (ofs)
    );

    always_comb begin
        s_d      = s_q;
        base_w   = {1'b0, int_word, frac_word[FRAC_W-1]};
        ofs_w    = {{(OUT_W-4){ofs[3]}}, ofs};
        s_d.ratio = base_w + ofs_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ratio <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio = s_q.ratio;

endmodule

// File: rtl/frac_ratio_mod_chk.sv
module frac_ratio_mod_chk #(
    parameter int INT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [INT_W-1:0] int_word,
    input logic             half_bit,
    input logic [INT_W+1:0] ratio
);

    localparam int OUT_W = INT_W + 2;

    logic             live_q;
    logic             seen_q = 1'b0;
    logic [OUT_W-1:0] base_q;
    logic [OUT_W-1:0] diff_w;
    logic             in_rng;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b1;
        base_q <= {1'b0, int_word, half_bit};
    end

    assign diff_w = ratio - base_q;
    assign in_rng = (diff_w <= OUT_W'(4)) || (diff_w >= OUT_W'((1 << OUT_W) - 3));

    // R1: output held at zero through reset
    a_r1_reset_zero: assert property (@(posedge clk)
        (seen_q && !rst_n) |-> (ratio == '0));

    // R3: ratio stays within -3..+4 half-steps of the programmed base
    a_r3_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> in_rng);

endmodule

module dither_lfsr_chk #(
    parameter int W = 23
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] sr
);

    logic live_q;
    logic seen_q = 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b1;
    end

    // R6: register moves up one place on every edge out of reset
    a_r6_lfsr_shift: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (sr[W-1:1] == $past(sr[W-2:0])));

    // R1: seed and all later states are nonzero
    a_r1_lfsr_nonzero: assert property (@(posedge clk)
        seen_q |-> (sr != '0));

endmodule

bind frac_ratio_mod frac_ratio_mod_chk #(.INT_W(INT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_word (int_word),
    .half_bit (frac_word[FRAC_W-1]),
    .ratio    (ratio)
);

bind dither_lfsr dither_lfsr_chk #(.W(W)) u_lchk (
    .clk   (clk),
    .rst_n (rst_n),
    .sr    (s_q.sr)
);

// File: tb/sim_frac_ratio_mod.sv
module sim_frac_ratio_mod;

    localparam int          INT_W = 8;
    localparam int          FRAC_W = 24;
    localparam logic [22:0] SEED = 23'h1ACE5;
    localparam int          MASK = (1 << 23) - 1;
    localparam int          OMOD = 1 << (INT_W + 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [INT_W-1:0]  int_word = '0;
    logic [FRAC_W-1:0] frac_word = '0;
    logic              dither_en = 1'b0;
    logic [INT_W+1:0]  ratio;

    frac_ratio_mod #(
        .INT_W     (INT_W),
        .FRAC_W    (FRAC_W),
        .LFSR_TAP  (17),
        .LFSR_SEED (SEED)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_word  (int_word),
        .frac_word (frac_word),
        .dither_en (dither_en),
        .ratio     (ratio)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_a [3];
    int m_c2h [$];
    int m_c3h [$];
    int m_lfsr;
    int m_exp;

    task automatic model_reset();
        foreach (m_a[i]) m_a[i] = 0;
        m_c2h  = {0};
        m_c3h  = {0, 0};
        m_lfsr = int'(SEED);
        m_exp  = 0;
    endtask

    task automatic model_step();
        int d, x, s, c1, c2, c3, y, fb;
        if (!rst_n) begin
            model_reset();
            return;
        end
        d = dither_en ? ((m_lfsr >> 22) & 1) : 0;
        x = int'(frac_word[22:0]) + d;
        s = m_a[0] + x;    c1 = s >> 23; m_a[0] = s & MASK;
        s = m_a[1] + m_a[0]; c2 = s >> 23; m_a[1] = s & MASK;
        s = m_a[2] + m_a[1]; c3 = s >> 23; m_a[2] = s & MASK;
        y = c1 + c2 - m_c2h[0] + c3 - 2 * m_c3h[0] + m_c3h[1];
        m_c2h[0] = c2;
        m_c3h.push_front(c3);
        void'(m_c3h.pop_back());
        fb = ((m_lfsr >> 22) ^ (m_lfsr >> 17)) & 1;
        m_lfsr = ((m_lfsr << 1) | fb) & MASK;
        m_exp = (2 * int'(int_word) + int'(frac_word[23]) + y + OMOD) % OMOD;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int obs_ofs();
        int d;
        d = int'(ratio) - 2 * int'(int_word) - int'(frac_word[23]);
        if (d > OMOD / 2) d -= OMOD;
        if (d < -OMOD / 2) d += OMOD;
        return d;
    endfunction

    // Predict the next edge, wait past it, and compare with the model.
    task automatic step(input string req);
        model_step();
        @(negedge clk);
        if ($isunknown(ratio)) check(req, "ratio unknown", -1, m_exp);
        else                   check(req, "ratio vs model", int'(ratio), m_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int sum, nz, wraps, o;
        int fr [5] = '{24'h123456, 24'hFFFFFF, 24'h000001, 24'h7FFFFF, 24'hABCDEF};
        model_reset();

        // R1: reset holds ratio at zero
        int_word = 8'd40;
        for (int i = 0; i < 3; i++) begin
            step("R1");
            check("R1", "ratio in reset", int'(ratio), 0);
        end
        rst_n = 1'b1;

        // R2: integer-only ratio
        for (int i = 0; i < 16; i++) begin
            step("R2");
            check("R2", "integer-only ratio", int'(ratio), 80);
        end

        // R7: top fraction bit adds one half-step only
        frac_word = 24'h800000;
        for (int i = 0; i < 16; i++) begin
            step("R7");
            check("R7", "half-step ratio", int'(ratio), 81);
        end

        // R4 / R9: quarter fraction, exact stage arithmetic, long-run mean
        frac_word = 24'h200000;
        sum = 0;
        for (int i = 0; i < 1024; i++) begin
            step("R9");
            sum += obs_ofs();
        end
        n_chk++;
        if (sum < 253 || sum > 259) begin
            n_fail++;
            $display("FAIL R4 offset sum: actual=%0d expected=256+-3", sum);
        end

        // R3 / R5 / R6: varied fractions and integers with dither on
        dither_en = 1'b1;
        foreach (fr[p]) begin
            frac_word = fr[p];
            int_word  = 8'(20 + 47 * p);
            for (int i = 0; i < 300; i++) begin
                step("R5");
                o = obs_ofs();
                n_chk++;
                if (o < -3 || o > 4) begin
                    n_fail++;
                    $display("FAIL R3 offset range: actual=%0d expected=-3..4", o);
                end
            end
        end

        // R5: dither alone moves the ratio when the fraction is zero
        frac_word = 24'h000000;
        int_word  = 8'd100;
        nz = 0;
        for (int i = 0; i < 200; i++) begin
            step("R5");
            if (obs_ofs() != 0) nz++;
        end
        n_chk++;
        if (nz == 0) begin
            n_fail++;
            $display("FAIL R5 dither effect: actual=%0d expected>0", nz);
        end

        // R8: zero integer word wraps on negative offsets
        int_word  = 8'd0;
        frac_word = 24'h155555;
        wraps = 0;
        for (int i = 0; i < 300; i++) begin
            step("R8");
            if (int'(ratio) >= OMOD - 3) wraps++;
        end
        n_chk++;
        if (wraps == 0) begin
            n_fail++;
            $display("FAIL R8 wrap seen: actual=%0d expected>0", wraps);
        end

        // R1 / R6: reset mid-run, then the register restarts from the seed
        int_word  = 8'd73;
        frac_word = 24'h000000;
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            step("R1");
            check("R1", "ratio in mid-run reset", int'(ratio), 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++) step("R6");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule